// File: doc/BRIEF.md
# DMA Request-to-Channel Scheduler

This block connects a set of peripheral DMA request lines to a group of DMA channels. It decides which channel a channel executor runs next. For each request source, software programs a channel mask. A rising edge on that source marks an event as pending on every channel in the mask. A single channel can collect requests from several sources. Software also sets a priority for each channel, can start channels directly, and can set or clear pending events by hand. It can stop channels and acknowledge completion interrupts.

A request can reach a channel that already holds a pending event, or that is being serviced at that moment. In that case the request is dropped and the channel's overflow error bit is set. A small two-state machine issues grants. In `ST_IDLE` it looks at the runnable channels. The transition IDLE→BUSY fires when at least one channel is runnable, and it registers the winner as the grant. In `ST_BUSY` the grant is held. The transition BUSY→IDLE fires when the executor pulses `done_in`, or when software stops the granted channel. The next pick is made from `ST_IDLE` on the following cycle.

Register map (8-bit address, 32-bit data, channel bit n is data bit n):
- 0x00 start: a write sets start flags.
- 0x01 pending: a write sets pending flags; a read returns them.
- 0x02 pending clear: a write clears the pending flags given in the mask.
- 0x03 stop: a write stops the masked channels; a read returns the start flags.
- 0x04 interrupt: a read returns the bits; a write of ones clears them.
- 0x05 overflow errors: a read returns them and clears them.
- 0x06 error interrupt mask.
- 0x20+n priority of channel n.
- 0x40+s mask of request source s.

Addresses that are not in this map read as zero.

Top module: `req_sched_top`

## Requirements
- R1: After reset, all flags, masks and priorities are zero, `grant_valid` and `irq` are low, and `rdata` is zero.
- R2: A rising edge on `req_in[s]` sets the pending flag of every channel whose bit is set in source s's mask (address 0x40+s). A level held high counts as one request.
- R3: A rising request that maps to a channel which is already pending, or currently granted, sets that channel's bit in the overflow register (0x05) and leaves its pending flag unchanged.
- R4: Reading 0x05 returns the overflow bits and clears them in the same cycle. An overflow detected in that cycle is kept.
- R5: A channel whose priority register (0x20+n) is zero is never granted, even while it is pending or started.
- R6: A channel is runnable when its priority is nonzero and it is started or pending. The grant goes to the runnable channel with the highest priority, and on equal priority to the lowest channel number.
- R7: Writing 0x00 sets the start flag of each channel given in the data; reading 0x03 returns the start flags.
- R8: Writing 0x01 sets pending flags, and writing 0x02 clears the pending flags given in the mask; reading 0x01 returns them.
- R9: Writing 0x03 clears the start and pending flags of the masked channels. If the granted channel is among them, `grant_valid` falls on the next cycle and no interrupt bit is set.
- R10: `done_in` while a grant is held clears that channel's start and pending flags and sets its interrupt bit (read at 0x04). Writing ones to 0x04 clears those bits.
- R11: `irq` is high while any interrupt bit is set, or any overflow bit is set whose bit in the error mask (0x06) is set.
- R12: A grant appears on the cycle after a runnable channel is seen in ST_IDLE, and is held until done or stop. After a done there is one ST_IDLE cycle before the next grant.
- R13: A read strobe loads `rdata` on the next clock edge, and `rdata` holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | NUM_REQ | Peripheral request lines |
| done_in | input | 1 | Executor finished the granted channel |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| grant_valid | output | 1 | A channel is granted |
| grant_ch | output | $clog2(NUM_CH) | Granted channel number |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with four channels, three request sources and three-bit priorities. At that size, overlapping masks are cheap to produce: one source feeding two channels, and two sources feeding one channel. Priority ties, a zero-priority channel left pending, and overflow on both a pending channel and a granted one are also within reach in a short run. The small channel count also lets a behavioural model track every flag exactly across stop, done and clear-on-read interactions.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } sched_state_e;

    localparam int A_START     = 8'h00;
    localparam int A_PEND_SET  = 8'h01;
    localparam int A_PEND_CLR  = 8'h02;
    localparam int A_STOP      = 8'h03;
    localparam int A_INTR      = 8'h04;
    localparam int A_ERR       = 8'h05;
    localparam int A_EMASK     = 8'h06;
    localparam int A_PRIO_BASE = 8'h20;
    localparam int A_MAP_BASE  = 8'h40;

endpackage

// File: rtl/sched_req_map.sv
module sched_req_map #(
    parameter int NUM_REQ = 16,
    parameter int NUM_CH  = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_REQ-1:0]          req_in,
    input  logic [NUM_REQ*NUM_CH-1:0]   map_flat,
    output logic [NUM_CH-1:0]           hit
);
    logic [NUM_REQ-1:0] req_q;
    logic [NUM_REQ-1:0] rise;

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_in;
    end

    assign rise = req_in & ~req_q;

    // Per channel: gather the column of mask bits across all sources.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [NUM_REQ-1:0] column;
        for (genvar s = 0; s < NUM_REQ; s++) begin : g_src
            assign column[s] = map_flat[s*NUM_CH + c];
        end
        assign hit[c] = |(rise & column);
    end
endmodule

// File: rtl/sched_pick.sv
module sched_pick #(
    parameter int NUM_CH = 32,
    parameter int PW     = 4
) (
    input  logic [NUM_CH-1:0]         runnable,
    input  logic [NUM_CH*PW-1:0]      prio_flat,
    output logic                      win_valid,
    output logic [$clog2(NUM_CH)-1:0] win_ch,
    output logic [PW-1:0]             win_prio
);
    localparam int CW = $clog2(NUM_CH);

    // Ascending scan with strict compare: lowest index keeps a tie.
    always_comb begin
        win_prio = '0;
        win_ch   = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (runnable[i] && (prio_flat[i*PW +: PW] > win_prio)) begin
                win_prio = prio_flat[i*PW +: PW];
                win_ch   = CW'(i);
            end
        end
        win_valid = (win_prio != '0);
    end
endmodule

// File: rtl/req_sched_top.sv
module req_sched_top
    import sched_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int NUM_REQ = 16,
    parameter int PW      = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ-1:0]        req_in,
    input  logic                      done_in,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [7:0]                addr,
    input  logic [31:0]               wdata,
    output logic [31:0]               rdata,
    output logic                      grant_valid,
    output logic [$clog2(NUM_CH)-1:0] grant_ch,
    output logic                      irq
);
    localparam int CW = $clog2(NUM_CH);

    sched_state_e state_q, state_d;

    logic [NUM_CH-1:0] start_q, pend_q, err_q, intr_q, emask_q;
    logic [PW-1:0]     prio_q [NUM_CH];
    logic [NUM_CH-1:0] map_q  [NUM_REQ];
    logic [CW-1:0]     gch_q;

    logic [NUM_REQ*NUM_CH-1:0] map_flat;
    logic [NUM_CH*PW-1:0]      prio_flat;
    logic [NUM_CH-1:0]         hit, runnable, prio_nz;
    logic                      win_valid;
    logic [CW-1:0]             win_ch;
    logic [PW-1:0]             win_prio;

    for (genvar s = 0; s < NUM_REQ; s++) begin : g_mapflat
        assign map_flat[s*NUM_CH +: NUM_CH] = map_q[s];
    end
    for (genvar c = 0; c < NUM_CH; c++) begin : g_prioflat
        assign prio_flat[c*PW +: PW] = prio_q[c];
        assign prio_nz[c]            = (prio_q[c] != '0);
    end

    sched_req_map #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_map (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .map_flat(map_flat), .hit(hit)
    );

    assign runnable = (pend_q | start_q) & prio_nz;

    sched_pick #(.NUM_CH(NUM_CH), .PW(PW)) u_pick (
        .runnable(runnable), .prio_flat(prio_flat),
        .win_valid(win_valid), .win_ch(win_ch), .win_prio(win_prio)
    );

    // Register decode and flag next-state
    logic [NUM_CH-1:0] wv, busy_vec, done_vec, stop_vec, new_err, req_set;
    logic [NUM_CH-1:0] start_d, pend_d, intr_d, err_d;
    logic              wr_start, wr_pset, wr_pclr, wr_stop, wr_intr, wr_emask, rd_err;
    logic              stop_grant;

    always_comb begin
        wv       = wdata[NUM_CH-1:0];
        wr_start = wr_en && (int'(addr) == A_START);
        wr_pset  = wr_en && (int'(addr) == A_PEND_SET);
        wr_pclr  = wr_en && (int'(addr) == A_PEND_CLR);
        wr_stop  = wr_en && (int'(addr) == A_STOP);
        wr_intr  = wr_en && (int'(addr) == A_INTR);
        wr_emask = wr_en && (int'(addr) == A_EMASK);
        rd_err   = rd_en && (int'(addr) == A_ERR);

        busy_vec   = (state_q == ST_BUSY) ? (NUM_CH'(1) << gch_q) : '0;
        done_vec   = done_in ? busy_vec : '0;
        stop_vec   = wr_stop ? wv : '0;
        stop_grant = |(stop_vec & busy_vec);
        new_err    = hit & (pend_q | busy_vec);
        req_set    = hit & ~pend_q & ~busy_vec;

        pend_d  = (pend_q | req_set | (wr_pset ? wv : '0))
                  & ~(wr_pclr ? wv : '0) & ~stop_vec & ~done_vec;
        start_d = (start_q | (wr_start ? wv : '0)) & ~stop_vec & ~done_vec;
        intr_d  = (intr_q & ~(wr_intr ? wv : '0)) | done_vec;
        err_d   = (rd_err ? '0 : err_q) | new_err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            pend_q  <= '0;
            intr_q  <= '0;
            err_q   <= '0;
            emask_q <= '0;
            for (int c = 0; c < NUM_CH; c++)  prio_q[c] <= '0;
            for (int s = 0; s < NUM_REQ; s++) map_q[s]  <= '0;
        end else begin
            start_q <= start_d;
            pend_q  <= pend_d;
            intr_q  <= intr_d;
            err_q   <= err_d;
            if (wr_emask) emask_q <= wv;
            for (int c = 0; c < NUM_CH; c++)
                if (wr_en && int'(addr) == A_PRIO_BASE + c) prio_q[c] <= wdata[PW-1:0];
            for (int s = 0; s < NUM_REQ; s++)
                if (wr_en && int'(addr) == A_MAP_BASE + s) map_q[s] <= wv;
        end
    end

    // Read port, registered
    logic [31:0] rd_val;
    always_comb begin
        rd_val = '0;
        unique case (int'(addr))
            A_START, A_STOP: rd_val = 32'(start_q);
            A_PEND_SET:      rd_val = 32'(pend_q);
            A_INTR:          rd_val = 32'(intr_q);
            A_ERR:           rd_val = 32'(err_q);
            A_EMASK:         rd_val = 32'(emask_q);
            default: begin
                for (int c = 0; c < NUM_CH; c++)
                    if (int'(addr) == A_PRIO_BASE + c) rd_val = 32'(prio_q[c]);
                for (int s = 0; s < NUM_REQ; s++)
                    if (int'(addr) == A_MAP_BASE + s) rd_val = 32'(map_q[s]);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_val;
    end

    // Grant state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gch_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && win_valid) gch_q <= win_ch;
        end
    end

    // Grant state machine: transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (win_valid)             state_d = ST_BUSY;
            ST_BUSY: if (done_in || stop_grant) state_d = ST_IDLE;
            default:                            state_d = ST_IDLE;
        endcase
    end

    // Grant state machine: outputs
    always_comb begin
        grant_valid = (state_q == ST_BUSY);
        grant_ch    = gch_q;
        irq         = (|intr_q) || (|(err_q & emask_q));
    end
endmodule

// File: rtl/req_sched_chk.sv
module req_sched_chk #(
    parameter int NUM_CH = 32,
    parameter int PW     = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      grant_valid,
    input logic [$clog2(NUM_CH)-1:0] grant_ch,
    input logic                      win_valid,
    input logic [$clog2(NUM_CH)-1:0] win_ch,
    input logic                      done_in,
    input logic                      wr_en,
    input logic                      rd_en,
    input logic [7:0]                addr,
    input logic [31:0]               wdata,
    input logic [NUM_CH-1:0]         err_q,
    input logic [NUM_CH-1:0]         intr_q,
    input logic [NUM_CH*PW-1:0]      prio_flat
);
    logic [PW-1:0] gprio;
    assign gprio = prio_flat[grant_ch*PW +: PW];

    // R5
    prio_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(grant_valid) && !$past(wr_en)) |-> (gprio != '0));

    // R12
    grant_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && win_valid) |=> (grant_valid && grant_ch == $past(win_ch)));

    // R10
    done_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && done_in) |=> (intr_q[$past(grant_ch)] && !grant_valid));

    // R9
    stop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && wr_en && addr == 8'h03 && wdata[grant_ch]) |=> !grant_valid);

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(err_q) & ~err_q) != '0) && $past(rst_n)) |-> $past(rd_en && addr == 8'h05));
endmodule

bind req_sched_top req_sched_chk #(.NUM_CH(NUM_CH), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .grant_valid(grant_valid), .grant_ch(grant_ch),
    .win_valid(win_valid), .win_ch(win_ch), .done_in(done_in), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .err_q(err_q), .intr_q(intr_q),
    .prio_flat(prio_flat)
);

// File: tb/tb_req_sched_top.sv
module tb_req_sched_top;
    localparam int NC = 4;
    localparam int NR = 3;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] req_in = '0;
    logic          done_in = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          grant_valid;
    logic [1:0]    grant_ch;
    logic          irq;

    int vectors = 0;
    int fails   = 0;

    always #10 clk = ~clk;

    req_sched_top #(.NUM_CH(NC), .NUM_REQ(NR), .PW(PW)) dut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .done_in(done_in),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .grant_valid(grant_valid), .grant_ch(grant_ch), .irq(irq)
    );

    // Behavioural reference model
    logic [NC-1:0] m_map [NR];
    int            m_prio [NC];
    logic [NC-1:0] m_start, m_pend, m_err, m_intr, m_emask;
    logic [NR-1:0] m_req_q;
    bit            m_busy;
    int            m_gch;
    logic [31:0]   m_rdata;
    logic [NC-1:0] t_hit, t_busy, t_wv, t_stop, t_done;
    int            t_best, t_win;
    logic [31:0]   t_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_map[s]) m_map[s] = '0;
            foreach (m_prio[c]) m_prio[c] = 0;
            m_start = '0; m_pend = '0; m_err = '0; m_intr = '0; m_emask = '0;
            m_req_q = '0; m_busy = 0; m_gch = 0; m_rdata = '0;
        end else begin
            t_wv = wdata[NC-1:0];
            t_hit = '0;
            for (int s = 0; s < NR; s++)
                for (int c = 0; c < NC; c++)
                    if (req_in[s] && !m_req_q[s] && m_map[s][c]) t_hit[c] = 1'b1;
            t_busy = '0;
            if (m_busy) t_busy[m_gch] = 1'b1;
            t_stop = (wr_en && addr == 8'h03) ? t_wv : '0;
            t_done = done_in ? t_busy : '0;
            if (rd_en) begin
                t_rd = '0;
                case (addr)
                    8'h00, 8'h03: t_rd = 32'(m_start);
                    8'h01: t_rd = 32'(m_pend);
                    8'h04: t_rd = 32'(m_intr);
                    8'h05: t_rd = 32'(m_err);
                    8'h06: t_rd = 32'(m_emask);
                    default: begin
                        if (addr >= 8'h20 && addr < 8'h20 + NC) t_rd = m_prio[addr - 8'h20];
                        if (addr >= 8'h40 && addr < 8'h40 + NR) t_rd = 32'(m_map[addr - 8'h40]);
                    end
                endcase
                m_rdata = t_rd;
            end
            // arbitration on pre-edge state
            if (!m_busy) begin
                t_best = 0; t_win = 0;
                for (int c = 0; c < NC; c++)
                    if ((m_pend[c] || m_start[c]) && m_prio[c] > t_best) begin
                        t_best = m_prio[c]; t_win = c;
                    end
                if (t_best > 0) begin m_busy = 1; m_gch = t_win; end
            end else if (done_in || (t_stop & t_busy) != '0) begin
                m_busy = 0;
            end
            if (rd_en && addr == 8'h05) m_err = '0;
            m_err = m_err | (t_hit & (m_pend | t_busy));
            m_pend = m_pend | (t_hit & ~m_pend & ~t_busy);
            if (wr_en && addr == 8'h01) m_pend = m_pend | t_wv;
            if (wr_en && addr == 8'h02) m_pend = m_pend & ~t_wv;
            m_pend = m_pend & ~t_stop & ~t_done;
            if (wr_en && addr == 8'h00) m_start = m_start | t_wv;
            m_start = m_start & ~t_stop & ~t_done;
            if (wr_en && addr == 8'h04) m_intr = m_intr & ~t_wv;
            m_intr = m_intr | t_done;
            if (wr_en && addr == 8'h06) m_emask = t_wv;
            if (wr_en && addr >= 8'h20 && addr < 8'h20 + NC) m_prio[addr - 8'h20] = int'(wdata[PW-1:0]);
            if (wr_en && addr >= 8'h40 && addr < 8'h40 + NR) m_map[addr - 8'h40] = t_wv;
            m_req_q = req_in;
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (grant_valid !== m_busy || (m_busy && int'(grant_ch) != m_gch)) begin
                fails++;
                $display("FAIL R6/R12 grant: got v=%0b ch=%0d, expected v=%0b ch=%0d",
                         grant_valid, grant_ch, m_busy, m_gch);
            end
            vectors++;
            if (irq !== ((m_intr != '0) || ((m_err & m_emask) != '0))) begin
                fails++;
                $display("FAIL R11 irq: got %0b, expected %0b", irq,
                         (m_intr != '0) || ((m_err & m_emask) != '0));
            end
            vectors++;
            if (rdata !== m_rdata) begin
                fails++;
                $display("FAIL R13 rdata: got %0h, expected %0h", rdata, m_rdata);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); wr_en = 1'b1; addr = 8'(a); wdata = 32'(d);
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk); rd_en = 1'b1; addr = 8'(a);
        @(negedge clk); rd_en = 1'b0; v = int'(rdata);
    endtask

    task automatic pulse_req(input int s, input int len);
        @(negedge clk); req_in[s] = 1'b1;
        repeat (len) @(negedge clk);
        req_in[s] = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); done_in = 1'b1;
        @(negedge clk); done_in = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, expected end before 20000 cycles");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : stim
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 grant_valid", int'(grant_valid), 0);
        check("R1 irq", int'(irq), 0);
        rd(8'h21, v); check("R1 prio reset", v, 0);

        wr(8'h40, 4'b0011); wr(8'h41, 4'b0010); wr(8'h42, 4'b1100);
        wr(8'h20, 2); wr(8'h21, 5); wr(8'h22, 0); wr(8'h23, 5);
        rd(8'h41, v); check("R2 map readback", v, 2);
        idle(2);
        check("R5 nothing runnable", int'(grant_valid), 0);

        // R2 level held three cycles counts once; fan-out to ch0 and ch1
        pulse_req(0, 3); idle(3);
        check("R6 highest prio grant", int'(grant_ch), 1);
        rd(8'h01, v); check("R2 pending fan-out", v, 3);
        rd(8'h05, v); check("R2 level counts once", v, 0);

        // R3 overflow on a pending and granted channel
        pulse_req(1, 1); idle(2);
        rd(8'h01, v); check("R3 pending unchanged", v, 3);
        check("R11 masked error no irq", int'(irq), 0);
        rd(8'h05, v); check("R3 overflow bit", v, 2);
        rd(8'h05, v); check("R4 clear on read", v, 0);

        // R10 done
        pulse_done(); idle(3);
        check("R12 next grant", int'(grant_ch), 0);
        check("R10 irq from done", int'(irq), 1);
        rd(8'h04, v); check("R10 intr bit", v, 2);
        wr(8'h04, 2); idle(1);
        check("R10 w1c clears irq", int'(irq), 0);

        // R5 zero priority channel stays pending
        pulse_req(2, 1); idle(2);
        pulse_done(); idle(3);
        check("R6 ch3 after ch0", int'(grant_ch), 3);
        pulse_done(); idle(3);
        check("R5 zero prio not granted", int'(grant_valid), 0);
        rd(8'h01, v); check("R5 ch2 still pending", v, 4);
        wr(8'h04, 15);

        // R8 clear pending
        wr(8'h02, 4); rd(8'h01, v); check("R8 pending cleared", v, 0);

        // R6 tie, lowest index wins
        wr(8'h01, 4'b1010); idle(3);
        check("R6 tie lowest index", int'(grant_ch), 1);
        pulse_done(); idle(3);
        check("R6 tie second", int'(grant_ch), 3);

        // R9 stop granted channel
        wr(8'h03, 4'b1000); idle(2);
        check("R9 grant dropped", int'(grant_valid), 0);
        rd(8'h04, v); check("R9 no intr on stop", v, 2);
        rd(8'h01, v); check("R9 pending cleared", v, 0);
        wr(8'h04, 15);

        // R7 start by software
        wr(8'h00, 4'b0001); idle(3);
        check("R7 started channel granted", int'(grant_ch), 0);
        rd(8'h03, v); check("R7 start flags", v, 1);

        // R11 error mask, R4 clearing
        pulse_req(0, 1); idle(2);
        check("R11 irq low before mask", int'(irq), 0);
        wr(8'h06, 1); idle(1);
        check("R11 unmasked error irq", int'(irq), 1);
        rd(8'h05, v); check("R3 busy overflow", v, 1);
        idle(1);
        check("R4 irq after clear", int'(irq), 0);
        pulse_done(); idle(4);
        check("R12 ch1 after ch0 done", int'(grant_ch), 1);
        pulse_done(); idle(3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule